// File: doc/BRIEF.md
# Dual-Clock Rewindable FIFO

This block is a first-in first-out buffer whose write port and read port run on unrelated clocks. The write side reports full and a programmable almost-full level. The read side reports empty and a programmable almost-empty level. Each side computes its flags only from registers clocked in its own domain. Pointers cross between the domains as Gray code through two-flop synchronizers. A flag can therefore lag the far side, but it never reports more room or more data than actually exists.

Two resets are provided. A master reset clears both pointers. While it is held, it also loads the read timing mode (standard or first-word-fall-through) and the two flag offsets. A partial reset clears only the pointers and the mark. The mode and offsets loaded by the last master reset stay in force, and the flags are recomputed from them.

The read side can be rewound. A pulse on `mark` records the current read location. Later, while `rt_n` is low, the read pointer is set back to that location. While a mark is held, the write side measures its free space from the mark instead of from the read pointer. Marked data therefore cannot be overwritten until the next reset.

Top module: `rewind_fifo`

## Requirements
- R1: After a master reset, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0, and in standard mode `rd_data`=0.
- R2: Words leave the FIFO in the order in which they were accepted.
- R3: `full` is 1 when DEPTH (2**ADDR_W) words are held. A write attempted while `full` is 1 is dropped and never appears on the read side.
- R4: A read attempted while `empty` is 1 does not move the read pointer and does not change `rd_data`. `empty` returns to 1 once every accepted word has been read.
- R5: `almost_full` is 1 when the write-side fill level is at least DEPTH minus the latched almost-full offset. The flag changes only on write-clock edges.
- R6: `almost_empty` is 1 when the read-side fill level is at most the latched almost-empty offset. The flag changes only on read-clock edges.
- R7: With `fwft_sel`=1 at master reset, `rd_data` shows the oldest word while `empty` is 0, without any read request. A read edge moves on to the next word.
- R8: With `fwft_sel`=0 at master reset, `rd_data` is loaded on the read-clock edge where `rd_en`=1 and `empty`=0. Otherwise it holds its value.
- R9: A partial reset empties the FIFO, clears the mark and sets `rd_data` to 0. It keeps the mode and both offsets latched at the last master reset, even if `fwft_sel` and the offset inputs have since changed.
- R10: `mark`=1 on a read edge records the read pointer, which is the location the next read returns. Each read edge with `rt_n`=0 sets the read pointer back to that location, and repeated rewinds return the same words.
- R11: When no mark has been recorded since the last reset, `rt_n`=0 has no effect on the read pointer.
- R12: While a mark is held, `full` counts the words from the mark to the write pointer. The FIFO can therefore report full even after the reader has consumed some of those words.

Ports are listed in the order of the port list; default widths are ADDR_W=4 and DATA_W=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; loads mode and offsets |
| prst_n | input | 1 | Partial reset, active low; pointers and mark only |
| fwft_sel | input | 1 | Mode sampled during master reset: 1 = fall-through, 0 = standard |
| af_offset | input | ADDR_W | Almost-full offset, latched during master reset |
| ae_offset | input | ADDR_W | Almost-empty offset, latched during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data |
| full | output | 1 | No free location (write domain) |
| almost_full | output | 1 | Fill level at or above threshold (write domain) |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read data |
| empty | output | 1 | No readable word (read domain) |
| almost_empty | output | 1 | Fill level at or below offset (read domain) |
| mark | input | 1 | Record the current read location |
| rt_n | input | 1 | Rewind to the mark, active low |

## Verification
The write-side flags follow the write pointer on the same write edge, so they are sampled two nanoseconds after that edge. Words crossing to the read side take the Gray register plus two synchronizer edges, so `empty` clears on the second read edge after the write. Space freed by reads reaches the write side after one read edge (the limit register) and two write edges. Before reading any flag that depends on the other domain, the bench waits eight cycles of each clock.

Standard-mode data is loaded on the read edge. The scoreboard monitor notes a pending pop at one falling read edge and compares at the next. Fall-through data is compared at the falling edge just before the pop.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rewind_fifo_rst_sync.sv
module rewind_fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rewind_fifo_ptr_sync.sv
module rewind_fifo_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, stab_q;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_in;
      stab_q <= meta_q;
    end
  end

  assign bin_out = gray_to_bin(stab_q);

  AST_SYNC_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stab_q ^ $past(stab_q)) <= 1); // R2
endmodule

// File: rtl/rewind_fifo_wr_side.sv
module rewind_fifo_wr_side #(
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] af_offset,
  input  logic [ADDR_W:0]   lim_bin,
  output logic [ADDR_W:0]   wgray,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              full,
  output logic              almost_full
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  logic [PW-1:0]     wbin_q, wbin_nxt, wr_level;
  logic [ADDR_W-1:0] af_q;
  logic              push;

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] level_of(input logic [PW-1:0] head,
                                             input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  always_ff @(posedge wr_clk) begin
    if (!mrst_n) af_q <= af_offset;
  end

  assign wr_level    = level_of(wbin_q, lim_bin);
  assign full        = (wr_level == DEPTH_V);
  assign almost_full = (wr_level >= (DEPTH_V - {1'b0, af_q}));
  assign push        = wr_en && !full;
  assign wbin_nxt    = wbin_q + PW'(push);
  assign mem_we      = push;
  assign mem_waddr   = wbin_q[ADDR_W-1:0];

  always_ff @(posedge wr_clk) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
    end else begin
      wbin_q <= wbin_nxt;
      wgray  <= bin_to_gray(wbin_nxt);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_level <= DEPTH_V); // R3
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wbin_q)); // R3
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
endmodule

// File: rtl/rewind_fifo_rd_side.sv
module rewind_fifo_rd_side
  import rewind_fifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              mrst_n,
  input  logic              fwft_sel,
  input  logic [ADDR_W-1:0] ae_offset,
  input  logic              rd_en,
  input  logic              mark,
  input  logic              rt_n,
  input  logic [ADDR_W:0]   wbin,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [ADDR_W:0]   lim_gray,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  rd_mode_e          mode_q;
  logic [ADDR_W-1:0] ae_q;
  logic [PW-1:0]     rptr_q, rptr_nxt, mark_q, lim_q, lim_nxt, lim_target, rd_level;
  logic              mark_vld_q;
  logic [DATA_W-1:0] rd_q;
  logic              pop, rt_evt, rt_ignored, mark_evt;

  function automatic logic [PW-1:0] bin_to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] level_of(input logic [PW-1:0] head,
                                             input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  always_ff @(posedge rd_clk) begin
    if (!mrst_n) begin
      mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
      ae_q   <= ae_offset;
    end
  end

  assign rd_level     = level_of(wbin, rptr_q);
  assign empty        = (rd_level == '0);
  assign almost_empty = (rd_level <= {1'b0, ae_q});

  assign rt_evt     = !rt_n && mark_vld_q;
  assign rt_ignored = !rt_n && !mark_vld_q;
  assign pop        = rd_en && !empty && !rt_evt;
  assign mark_evt   = mark && !rt_evt;

  always_comb begin
    if (rt_evt)   rptr_nxt = mark_q;
    else if (pop) rptr_nxt = rptr_q + PW'(1);
    else          rptr_nxt = rptr_q;
  end

  // The limit seen by the writer steps by one per cycle towards the mark or
  // the read pointer, so its Gray image never changes more than one bit.
  assign lim_target = mark_vld_q ? mark_q : rptr_q;
  assign lim_nxt    = (lim_q != lim_target) ? lim_q + PW'(1) : lim_q;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      rptr_q     <= '0;
      mark_q     <= '0;
      mark_vld_q <= 1'b0;
      lim_q      <= '0;
      lim_gray   <= '0;
      rd_q       <= '0;
    end else begin
      rptr_q   <= rptr_nxt;
      lim_q    <= lim_nxt;
      lim_gray <= bin_to_gray(lim_nxt);
      if (mark_evt) begin
        mark_q     <= rptr_q;
        mark_vld_q <= 1'b1;
      end
      if (pop && mode_q == MODE_STD) rd_q <= mem_rdata;
    end
  end

  assign mem_raddr = rptr_q[ADDR_W-1:0];
  assign rd_data   = (mode_q == MODE_FWFT) ? mem_rdata : rd_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && empty && rt_n) |=> $stable(rptr_q)); // R4
  AST_RT_REWIND: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rt_evt |=> (rptr_q == $past(mark_q))); // R10
  AST_RT_IGNORED: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rt_ignored && !rd_en) |=> $stable(rptr_q)); // R11
  AST_LIM_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(lim_gray ^ $past(lim_gray)) <= 1); // R12
  AST_LIM_BEHIND: assert property (@(posedge rd_clk) disable iff (!rst_n)
    level_of(rptr_q, lim_q) <= DEPTH_V); // R12
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic [ADDR_W-1:0] af_offset,
  input  logic [ADDR_W-1:0] ae_offset,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  input  logic              mark,
  input  logic              rt_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic              any_rst_n;
  logic              wr_rst_n, wr_mrst_n, rd_rst_n, rd_mrst_n;
  logic [PW-1:0]     wgray, wbin_rd, lim_gray, lim_bin_wr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign any_rst_n = mrst_n && prst_n;

  rewind_fifo_rst_sync #(.STAGES(2)) u_wr_any  (.clk(wr_clk), .arst_n(any_rst_n), .srst_n(wr_rst_n));
  rewind_fifo_rst_sync #(.STAGES(2)) u_wr_mst  (.clk(wr_clk), .arst_n(mrst_n),    .srst_n(wr_mrst_n));
  rewind_fifo_rst_sync #(.STAGES(2)) u_rd_any  (.clk(rd_clk), .arst_n(any_rst_n), .srst_n(rd_rst_n));
  rewind_fifo_rst_sync #(.STAGES(2)) u_rd_mst  (.clk(rd_clk), .arst_n(mrst_n),    .srst_n(rd_mrst_n));

  rewind_fifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk      (wr_clk),
    .rst_n       (wr_rst_n),
    .mrst_n      (wr_mrst_n),
    .wr_en       (wr_en),
    .af_offset   (af_offset),
    .lim_bin     (lim_bin_wr),
    .wgray       (wgray),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .full        (full),
    .almost_full (almost_full)
  );

  rewind_fifo_ptr_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wgray), .bin_out(wbin_rd)
  );

  rewind_fifo_ptr_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(lim_gray), .bin_out(lim_bin_wr)
  );

  rewind_fifo_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rd_clk       (rd_clk),
    .rst_n        (rd_rst_n),
    .mrst_n       (rd_mrst_n),
    .fwft_sel     (fwft_sel),
    .ae_offset    (ae_offset),
    .rd_en        (rd_en),
    .mark         (mark),
    .rt_n         (rt_n),
    .wbin         (wbin_rd),
    .mem_rdata    (mem_rdata),
    .mem_raddr    (mem_raddr),
    .lim_gray     (lim_gray),
    .rd_data      (rd_data),
    .empty        (empty),
    .almost_empty (almost_empty)
  );

  always_ff @(posedge wr_clk) begin
    if (mem_we) mem_q[mem_waddr] <= wr_data;
  end

  assign mem_rdata = mem_q[mem_raddr];
endmodule

// File: tb/rewind_fifo_bench.sv
module rewind_fifo_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0;
  logic mrst_n = 1, prst_n = 1, fwft_sel = 0;
  logic [AW-1:0] af_offset = 3, ae_offset = 2;
  logic wr_en = 0, rd_en = 0, mark = 0, rt_n = 1;
  logic [DW-1:0] wr_data = '0;
  logic full, almost_full, empty, almost_empty;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  bit done = 0;
  bit fwft_b = 0;
  bit std_pend = 0;
  logic [DW-1:0] q [$];

  always #10 wr_clk = ~wr_clk;
  always #14 rd_clk = ~rd_clk;

  rewind_fifo #(.ADDR_W(AW), .DATA_W(DW)) u_rewind_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .af_offset(af_offset), .ae_offset(ae_offset),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
    .mark(mark), .rt_n(rt_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares outgoing words against the expected queue.
  always @(negedge rd_clk) begin
    if (!mrst_n || !prst_n) begin
      std_pend = 0;
    end else begin
      if (std_pend) begin
        std_pend = 0;
        if (q.size() == 0) check("R2", "unexpected std word", 32'(rd_data), 32'hFFFF_FFFF);
        else check("R8", "std word", 32'(rd_data), 32'(q.pop_front()));
      end
      if (rd_en && !empty && rt_n) begin
        if (fwft_b) begin
          if (q.size() == 0) check("R2", "unexpected fwft word", 32'(rd_data), 32'hFFFF_FFFF);
          else check("R7", "fwft word", 32'(rd_data), 32'(q.pop_front()));
        end else begin
          std_pend = 1;
        end
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge rd_clk);
    repeat (n) @(posedge wr_clk);
  endtask

  task automatic wr_word(input logic [DW-1:0] d, input bit expect_ok);
    @(posedge wr_clk); #2;
    wr_en = 1; wr_data = d;
    if (expect_ok) q.push_back(d);
    @(posedge wr_clk); #2;
    wr_en = 0;
  endtask

  task automatic rd_word();
    @(posedge rd_clk); #2;
    rd_en = 1;
    @(posedge rd_clk); #2;
    rd_en = 0;
  endtask

  task automatic pulse_mark();
    @(posedge rd_clk); #2; mark = 1;
    @(posedge rd_clk); #2; mark = 0;
  endtask

  task automatic pulse_rt();
    @(posedge rd_clk); #2; rt_n = 0;
    @(posedge rd_clk); #2; rt_n = 1;
  endtask

  task automatic do_reset(input bit master);
    if (master) mrst_n = 0; else prst_n = 0;
    settle(4);
    mrst_n = 1; prst_n = 1;
    q.delete();
    settle(8);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    // Standard mode, af offset 3 (threshold 13), ae offset 2.
    fwft_sel = 0; af_offset = 3; ae_offset = 2; fwft_b = 0;
    do_reset(1);
    @(negedge rd_clk);
    check("R1", "empty", 32'(empty), 1);
    check("R1", "almost_empty", 32'(almost_empty), 1);
    check("R1", "rd_data", 32'(rd_data), 0);
    @(negedge wr_clk);
    check("R1", "full", 32'(full), 0);
    check("R1", "almost_full", 32'(almost_full), 0);

    // R4: read on empty has no effect.
    rd_word();
    settle(2);
    @(negedge rd_clk);
    check("R4", "empty after empty read", 32'(empty), 1);
    check("R4", "rd_data after empty read", 32'(rd_data), 0);

    // R6 / R2 / R8
    for (int i = 0; i < 3; i++) wr_word(DW'(16'h1100 + i), 1);
    settle(8);
    @(negedge rd_clk);
    check("R6", "almost_empty at level 3", 32'(almost_empty), 0);
    check("R4", "empty at level 3", 32'(empty), 0);
    rd_word();
    check("R6", "almost_empty at level 2", 32'(almost_empty), 1);
    rd_word();
    rd_word();
    settle(2);
    held = rd_data;
    check("R8", "last word loaded", 32'(held), 32'h1102);
    settle(3);
    check("R8", "rd_data held without read", 32'(rd_data), 32'(held));

    // R5 / R3: fill to full, then a dropped write.
    settle(6);
    for (int i = 0; i < DEPTH; i++) begin
      wr_word(DW'(16'h2200 + i), 1);
      if (i == 11) check("R5", "almost_full at 12", 32'(almost_full), 0);
      if (i == 12) check("R5", "almost_full at 13", 32'(almost_full), 1);
      if (i == 14) check("R3", "full at 15", 32'(full), 0);
    end
    check("R3", "full at DEPTH", 32'(full), 1);
    wr_word(16'hDEAD, 0);
    check("R3", "full after dropped write", 32'(full), 1);
    settle(8);
    for (int i = 0; i < DEPTH; i++) rd_word();
    settle(8);
    @(negedge rd_clk);
    check("R3", "dropped word absent (empty)", 32'(empty), 1);
    check("R2", "scoreboard drained", 32'(q.size()), 0);

    // R11: rewind with no mark.
    wr_word(16'h3301, 1);
    wr_word(16'h3302, 1);
    settle(8);
    rd_word();
    pulse_rt();
    rd_word();
    settle(4);
    @(negedge rd_clk);
    check("R11", "empty after ignored rewind", 32'(empty), 1);
    check("R11", "scoreboard drained", 32'(q.size()), 0);

    // R9: partial reset keeps mode and offsets.
    wr_word(16'h4401, 0);
    wr_word(16'h4402, 0);
    fwft_sel = 1; af_offset = 6; ae_offset = 5;
    do_reset(0);
    @(negedge rd_clk);
    check("R9", "empty after partial reset", 32'(empty), 1);
    check("R9", "rd_data cleared", 32'(rd_data), 0);
    @(negedge wr_clk);
    check("R9", "full after partial reset", 32'(full), 0);
    for (int i = 0; i < 3; i++) wr_word(DW'(16'h5500 + i), 1);
    settle(8);
    @(negedge rd_clk);
    check("R9", "ae offset kept", 32'(almost_empty), 0);
    check("R9", "std mode kept", 32'(rd_data), 0);
    for (int i = 3; i < 13; i++) begin
      wr_word(DW'(16'h5500 + i), 1);
      if (i == 11) check("R9", "af offset kept at 12", 32'(almost_full), 0);
    end
    check("R9", "af offset kept at 13", 32'(almost_full), 1);
    settle(8);
    for (int i = 0; i < 13; i++) rd_word();
    settle(8);
    check("R2", "scoreboard drained after prst", 32'(q.size()), 0);

    // R7: fall-through mode.
    fwft_sel = 1; af_offset = 3; ae_offset = 2;
    do_reset(1);
    fwft_b = 1;
    wr_word(16'h6601, 1);
    wr_word(16'h6602, 1);
    settle(8);
    @(negedge rd_clk);
    check("R7", "head shown without read", 32'(rd_data), 32'h6601);
    rd_word();
    @(negedge rd_clk);
    check("R7", "next word after read", 32'(rd_data), 32'h6602);
    rd_word();
    settle(4);

    // R10: mark and repeated rewinds.
    for (int i = 0; i < 4; i++) wr_word(DW'(16'h7700 + i), 1);
    settle(8);
    pulse_mark();
    rd_word();
    rd_word();
    pulse_rt();
    q.delete();
    for (int i = 0; i < 4; i++) q.push_back(DW'(16'h7700 + i));
    @(negedge rd_clk);
    check("R10", "rewound head", 32'(rd_data), 32'h7700);
    for (int i = 0; i < 4; i++) rd_word();
    pulse_rt();
    for (int i = 0; i < 4; i++) q.push_back(DW'(16'h7700 + i));
    @(negedge rd_clk);
    check("R10", "second rewind head", 32'(rd_data), 32'h7700);
    for (int i = 0; i < 4; i++) rd_word();
    settle(8);
    check("R10", "scoreboard drained", 32'(q.size()), 0);

    // R12: full counted from the mark.
    for (int i = 0; i < 11; i++) wr_word(DW'(16'h8800 + i), 0);
    check("R12", "not full at 15 from mark", 32'(full), 0);
    wr_word(16'h880B, 0);
    check("R12", "full at 16 from mark", 32'(full), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule